// File: doc/BRIEF.md
# Delayed-Reset Phase-Frequency Detector Pair with Lock Indicator

This block holds two phase-frequency detectors, a main one and an auxiliary one. Each detector compares a divided reference against a divided feedback signal. Each has two command flags. UP asks the oscillator to speed up (source current) and DOWN asks it to slow down (sink current).

A flag is set by the falling edge of its divider signal. Once both flags of a detector are set, they are not cleared at once. They stay set until the next rising edge of the undivided reference clock. Near zero phase error this gives both commands a short pulse of up to one reference period, so there is no dead zone.

Each detector judges its own lock from how long exactly one of its flags is active, counted in reference-clock cycles. A single output pin carries the combined lock state or, under a two-bit test selection, one of the divider signals. All inputs are brought through synchronizers into one system clock that runs faster than the reference clock.

Top module: `pfd_lock_top`

## Requirements
- R1: A falling edge on a divider input is seen through a two-stage synchronizer plus one edge register. The matching flag (UP for the reference input, DOWN for the feedback input) goes high on the third rising `clk` edge after the input falls, and not earlier.
- R2: When the reference signal falls before the feedback signal, only UP is active during the gap. When the feedback signal falls first, only DOWN is active during the gap. When both fall together, neither flag is ever active alone.
- R3: Once both flags of a detector are set, both stay set until the first rising edge of `ref_clk` that follows. Both then clear together, so the time both are high lasts at least one `clk` cycle and at most one reference period.
- R4: While its enable is low, a detector keeps UP and DOWN low whatever its inputs do, and it counts as locked.
- R5: Lock is judged each time both flags of an enabled detector become set. The detector counts `ref_clk` rising edges that occur while exactly one of its flags is active. It is locked when that count is below `LOCK_LIM` (default 1). After reset, or after being disabled, an enabled detector is unlocked.
- R6: In normal mode `lock_out` is high only when both detectors report lock.
- R7: The pin selection code picks what `lock_out` carries, each source taken after the input synchronizer:
  - 00: the combined lock of R6.
  - 01: the main reference divider signal.
  - 10: the auxiliary feedback divider signal.
  - 11: the main feedback divider signal.

  Reset selects 00.
- R8: The selection code is taken from `tsel_in` only in a cycle where `tsel_wr` is high. At any other time `tsel_in` has no effect on `lock_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Undivided reference clock that times the delayed clear |
| main_ref_div | input | 1 | Main detector divided reference (idle high) |
| main_fb_div | input | 1 | Main detector divided feedback (idle high) |
| aux_ref_div | input | 1 | Auxiliary detector divided reference (idle high) |
| aux_fb_div | input | 1 | Auxiliary detector divided feedback (idle high) |
| main_en | input | 1 | Main detector enable |
| aux_en | input | 1 | Auxiliary detector enable |
| tsel_wr | input | 1 | Load strobe for the pin selection code |
| tsel_in | input | 2 | Pin selection code |
| main_up | output | 1 | Main detector speed-up command |
| main_dn | output | 1 | Main detector slow-down command |
| aux_up | output | 1 | Auxiliary detector speed-up command |
| aux_dn | output | 1 | Auxiliary detector slow-down command |
| lock_out | output | 1 | Combined lock or selected divider signal |

## Verification
The properties assume that every divider input and `ref_clk` holds each level for at least a few `clk` cycles, so every edge survives the synchronizer as a single pulse. They also assume that each divider falls at most once between clears. The stimulus changes inputs only on falling `clk` edges. It runs `ref_clk` at one eighth of `clk`. It keeps each divider low for at least thirty cycles before returning it high. It starts every comparison one cycle after a reference-clock rise, so the number of reference edges that fall inside a phase gap is known in advance.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  typedef enum logic [1:0] {
    PIN_LOCK = 2'b00,
    PIN_REF  = 2'b01,
    PIN_AUX  = 2'b10,
    PIN_MAIN = 2'b11
  } pin_sel_e;

  // Set wins over clear so an edge in the clearing cycle is not lost.
  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Locked when the single-sided window spanned fewer reference edges than the limit.
  function automatic logic lock_verdict(int unsigned edges, int unsigned limit);
    return edges < limit;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1,
  parameter bit   FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic edge_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= {(LAST+1){RST_VAL}};
    else        pipe <= {pipe[LAST-1:0], din};
  end

  assign lvl = pipe[LAST-1];

  generate
    if (FALLING) begin : g_fall
      assign edge_o = pipe[LAST] & ~pipe[LAST-1];
    end else begin : g_rise
      assign edge_o = ~pipe[LAST] & pipe[LAST-1];
    end
  endgenerate
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
#(
  parameter int LOCK_LIM = 1,
  localparam int CNT_W   = $clog2(LOCK_LIM + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_fall,
  input  logic fb_fall,
  input  logic ref_rise,
  output logic up,
  output logic dn,
  output logic meet,
  output logic locked
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic up_q, dn_q, both_q, lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic both, clr, run;

  assign both = up_q & dn_q;
  assign clr  = both & ref_rise;
  assign meet = both & ~both_q;
  assign run  = (up_q ^ dn_q) & ref_rise & (cnt_q != CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      both_q <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      up_q   <= next_flag(up_q, ref_fall, clr);
      dn_q   <= next_flag(dn_q, fb_fall, clr);
      both_q <= both;
      if (meet) begin
        cnt_q  <= '0;
        lock_q <= lock_verdict(32'(cnt_q), 32'(LOCK_LIM));
      end else if (run) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign up     = up_q;
  assign dn     = dn_q;
  assign locked = en ? lock_q : 1'b1;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_LIM    = 1,
  localparam int NDET       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       main_ref_div,
  input  logic       main_fb_div,
  input  logic       aux_ref_div,
  input  logic       aux_fb_div,
  input  logic       main_en,
  input  logic       aux_en,
  input  logic       tsel_wr,
  input  logic [1:0] tsel_in,
  output logic       main_up,
  output logic       main_dn,
  output logic       aux_up,
  output logic       aux_dn,
  output logic       lock_out
);
  // index 0 = main, 1 = auxiliary
  logic [NDET-1:0] ref_in, fb_in, en_v;
  logic [NDET-1:0] ref_lvl_v, fb_lvl_v, ref_fall_v, fb_fall_v;
  logic [NDET-1:0] up_v, dn_v, meet_v, lock_v;
  logic            ref_rise, ref_lvl_unused;
  pin_sel_e        sel_q;

  assign ref_in = {aux_ref_div, main_ref_div};
  assign fb_in  = {aux_fb_div,  main_fb_div};
  assign en_v   = {aux_en,      main_en};

  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALLING(1'b0)) u_refclk (
    .clk(clk), .rst_n(rst_n), .din(ref_clk), .lvl(ref_lvl_unused), .edge_o(ref_rise));

  for (genvar g = 0; g < NDET; g++) begin : g_det
    edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALLING(1'b1)) u_ref (
      .clk(clk), .rst_n(rst_n), .din(ref_in[g]), .lvl(ref_lvl_v[g]), .edge_o(ref_fall_v[g]));
    edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALLING(1'b1)) u_fb (
      .clk(clk), .rst_n(rst_n), .din(fb_in[g]), .lvl(fb_lvl_v[g]), .edge_o(fb_fall_v[g]));
    pfd_core #(.LOCK_LIM(LOCK_LIM)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en_v[g]),
      .ref_fall(ref_fall_v[g]), .fb_fall(fb_fall_v[g]), .ref_rise(ref_rise),
      .up(up_v[g]), .dn(dn_v[g]), .meet(meet_v[g]), .locked(lock_v[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= PIN_LOCK;
    else if (tsel_wr) sel_q <= pin_sel_e'(tsel_in);
  end

  always_comb begin
    unique case (sel_q)
      PIN_LOCK: lock_out = &lock_v;
      PIN_REF:  lock_out = ref_lvl_v[0];
      PIN_AUX:  lock_out = fb_lvl_v[1];
      default:  lock_out = fb_lvl_v[0];
    endcase
  end

  assign main_up = up_v[0];
  assign main_dn = dn_v[0];
  assign aux_up  = up_v[1];
  assign aux_dn  = dn_v[1];
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] en,
  input logic       ref_rise,
  input logic [1:0] ref_fall,
  input logic [1:0] fb_fall,
  input logic [1:0] up,
  input logic [1:0] dn
);
  // R4
  main_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |=> (!up[0] && !dn[0]));

  // R4
  aux_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |=> (!up[1] && !dn[1]));

  // R1
  main_up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en[0] && ref_fall[0]) |=> up[0]);

  // R1
  aux_dn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en[1] && fb_fall[1]) |=> dn[1]);

  // R3
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up[0] && en[0] && !ref_rise) |=> up[0]);

  // R3
  main_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up[0] && dn[0] && en[0] && ref_rise && !ref_fall[0] && !fb_fall[0])
      |=> (!up[0] && !dn[0]));
endmodule

bind pfd_lock_top pfd_lock_chk chk (
  .clk(clk), .rst_n(rst_n), .en({aux_en, main_en}), .ref_rise(ref_rise),
  .ref_fall(ref_fall_v), .fb_fall(fb_fall_v), .up(up_v), .dn(dn_v));

// File: tb/pfd_lock_top_test.sv
module pfd_lock_top_test;
  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic main_ref_div = 1'b1, main_fb_div = 1'b1, aux_ref_div = 1'b1, aux_fb_div = 1'b1;
  logic main_en = 1'b1, aux_en = 1'b1, tsel_wr = 1'b0;
  logic [1:0] tsel_in = 2'b00;
  logic main_up, main_dn, aux_up, aux_dn, lock_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // monitor state
  bit mon_clr = 1'b0;
  int mon_det = 0;
  bit up_alone, dn_alone;
  int overlap;

  // gap in clk cycles (positive: reference first), expected lock
  localparam int VEC_N = 7;
  localparam int VEC [VEC_N][2] = '{'{0,1}, '{9,0}, '{1,1}, '{-12,0}, '{-3,1}, '{20,0}, '{6,1}};

  pfd_lock_top uut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .main_ref_div(main_ref_div), .main_fb_div(main_fb_div),
    .aux_ref_div(aux_ref_div), .aux_fb_div(aux_fb_div),
    .main_en(main_en), .aux_en(aux_en), .tsel_wr(tsel_wr), .tsel_in(tsel_in),
    .main_up(main_up), .main_dn(main_dn), .aux_up(aux_up), .aux_dn(aux_dn),
    .lock_out(lock_out));

  always #5 clk = ~clk;
  always #40 ref_clk = ~ref_clk;

  always @(negedge clk) begin
    logic u, d;
    u = (mon_det == 0) ? main_up : aux_up;
    d = (mon_det == 0) ? main_dn : aux_dn;
    if (mon_clr) begin
      up_alone = 1'b0; dn_alone = 1'b0; overlap = 0;
    end else begin
      if (u && !d) up_alone = 1'b1;
      if (d && !u) dn_alone = 1'b1;
      if (u && d)  overlap++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fall_sig(input int det, input bit fb);
    if (det == 0) begin if (fb) main_fb_div = 1'b0; else main_ref_div = 1'b0; end
    else          begin if (fb) aux_fb_div  = 1'b0; else aux_ref_div  = 1'b0; end
  endtask

  task automatic idle_all();
    main_ref_div = 1'b1; main_fb_div = 1'b1; aux_ref_div = 1'b1; aux_fb_div = 1'b1;
  endtask

  // starts one clk cycle after a ref_clk rise: next rise is 7 cycles later
  task automatic drive_pair(input int det, input int gap);
    int mag;
    mag = (gap < 0) ? -gap : gap;
    mon_det = det;
    @(posedge ref_clk); #1;
    mon_clr = 1'b1;
    @(negedge clk);
    if (gap == 0) begin fall_sig(det, 1'b0); fall_sig(det, 1'b1); end
    else fall_sig(det, gap < 0);
    #2 mon_clr = 1'b0;
    if (gap != 0) begin
      repeat (mag) @(negedge clk);
      fall_sig(det, gap > 0);
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic release_pair();
    idle_all();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_sel(input logic [1:0] code, input bit wr);
    @(negedge clk);
    tsel_in = code; tsel_wr = wr;
    @(negedge clk);
    tsel_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5 R7: reset leaves detectors unlocked and the pin in lock mode
    check(lock_out == 1'b0, "R5 reset lock", lock_out, 0);
    check({main_up, main_dn, aux_up, aux_dn} == 4'b0, "R1 reset flags",
          {main_up, main_dn, aux_up, aux_dn}, 0);

    // vector table on the main detector, auxiliary disabled (R4: counts as locked)
    aux_en = 1'b0;
    for (int i = 0; i < VEC_N; i++) begin
      int g, exp_lock;
      g = VEC[i][0]; exp_lock = VEC[i][1];
      drive_pair(0, g);
      check(up_alone == (g > 0), "R2 up alone", int'(up_alone), int'(g > 0));
      check(dn_alone == (g < 0), "R2 dn alone", int'(dn_alone), int'(g < 0));
      check(overlap >= 1 && overlap <= 8, "R3 overlap width", overlap, 8);
      check(!main_up && !main_dn, "R3 cleared", {main_up, main_dn}, 0);
      check(lock_out == exp_lock[0], "R5 lock verdict", lock_out, exp_lock);
      release_pair();
    end

    // R4: disabled main ignores its inputs; both disabled counts as locked
    main_en = 1'b0;
    repeat (2) @(negedge clk);
    main_ref_div = 1'b0;
    repeat (8) @(negedge clk);
    check(!main_up && !main_dn, "R4 disabled quiet", {main_up, main_dn}, 0);
    check(lock_out == 1'b1, "R4 disabled locked", lock_out, 1);
    release_pair();

    // R1: exact latency on the auxiliary detector
    aux_en = 1'b1;
    @(posedge ref_clk); #1;
    @(negedge clk);
    aux_ref_div = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(aux_up == 1'b0, "R1 not before third edge", aux_up, 0);
    @(posedge clk); @(negedge clk);
    check(aux_up == 1'b1, "R1 third edge", aux_up, 1);
    aux_fb_div = 1'b0;
    repeat (30) @(negedge clk);
    check(!aux_up && !aux_dn, "R3 aux cleared", {aux_up, aux_dn}, 0);
    check(lock_out == 1'b1, "R6 aux locked main off", lock_out, 1);
    release_pair();

    // R6: aux unlocked pulls lock low even with main locked
    drive_pair(1, -12);
    check(dn_alone && !up_alone, "R2 aux dn first", int'(dn_alone), 1);
    check(lock_out == 1'b0, "R6 aux unlocked", lock_out, 0);
    release_pair();
    main_en = 1'b1;
    repeat (2) @(negedge clk);
    drive_pair(0, 0);
    check(lock_out == 1'b0, "R6 main locked aux not", lock_out, 0);
    release_pair();
    drive_pair(1, 1);
    check(lock_out == 1'b1, "R6 both locked", lock_out, 1);
    release_pair();

    // R8: code without strobe is ignored
    main_en = 1'b0; aux_en = 1'b0;
    set_sel(2'b11, 1'b0);
    main_fb_div = 1'b0;
    repeat (4) @(negedge clk);
    check(lock_out == 1'b1, "R8 no strobe", lock_out, 1);
    idle_all();
    repeat (4) @(negedge clk);

    // R7: test routing
    set_sel(2'b01, 1'b1);
    main_ref_div = 1'b0;
    repeat (3) @(negedge clk);
    check(lock_out == 1'b0, "R7 ref route low", lock_out, 0);
    main_ref_div = 1'b1;
    repeat (3) @(negedge clk);
    check(lock_out == 1'b1, "R7 ref route high", lock_out, 1);
    set_sel(2'b10, 1'b1);
    aux_fb_div = 1'b0; main_fb_div = 1'b1;
    repeat (3) @(negedge clk);
    check(lock_out == 1'b0, "R7 aux route", lock_out, 0);
    set_sel(2'b11, 1'b1);
    aux_fb_div = 1'b1;
    repeat (3) @(negedge clk);
    check(lock_out == 1'b1, "R7 main route high", lock_out, 1);
    main_fb_div = 1'b0;
    repeat (3) @(negedge clk);
    check(lock_out == 1'b0, "R7 main route low", lock_out, 0);
    set_sel(2'b00, 1'b1);
    repeat (2) @(negedge clk);
    check(lock_out == 1'b1, "R7 back to lock", lock_out, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule